// File: doc/BRIEF.md
# Multi-Channel Auto-Reload Timer

A bank of independent 16-bit up-counters sits behind a small register window. Each channel has its own clock divider choice, reload value, run/stop bit and mode bit. Once started, a channel counts up from its reload value at the divided rate. When it steps past the all-ones value, it wraps back to the reload value, latches a sticky overflow flag and drives its own interrupt line. In periodic mode it keeps running. In single-shot mode it stops itself after the first wrap.

Software programs a channel with single-cycle register writes and reads its state back through a combinational read port. It clears the overflow flag by writing 1 to it. The interrupt lines go to an external interrupt controller, which is not part of this block. With the default parameters there are six channels.

Top module: `multi_reload_timer`

## Requirements
- R1: After reset every channel has enable off, mode periodic, divider select 0, reload 0, count 0 and flag clear. Every irq bit is low.
- R2: The register address is {channel, offset}, with the offset in the two low bits. Offset 0 is control: bit 0 enable, bit 1 single-shot when 1, bits 4:2 divider select. Offset 1 is reload, offset 2 is count (read-only), offset 3 is status (bit 0 overflow flag). Reads are combinational and return 0 in unused bits.
- R3: Writing control with enable 1 to a stopped channel loads count from reload and restarts that channel's divider. With select k, count rises by one on every 2^k-th clock edge after the start edge.
- R4: A step from 0xFFFF loads count with the reload value and sets the flag. With reload value V, the first wrap falls on edge (65536-V)*2^k after the start edge.
- R5: In periodic mode (control bit 1 = 0) the channel stays enabled after a wrap, and the next wrap falls (65536-V)*2^k edges later.
- R6: In single-shot mode (control bit 1 = 1) the wrap clears the enable bit, and count then holds the reload value.
- R7: irq[i] follows channel i's flag. The flag stays set until a status write with bit 0 = 1. A status write with bit 0 = 0 has no effect. A wrap in the same cycle as a clear leaves the flag set.
- R8: A reload write while a channel is running leaves the current count unchanged. The new value is used at the next wrap.
- R9: A write to one channel changes no register of any other channel.
- R10: Writing enable 0 stops the count, which then holds its value. Writing control with enable 1 to a channel that is already running does not reload the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 5 | Register address {channel, offset} |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq | output | 6 | One overflow interrupt per channel |

## Verification
The bench builds the block with its default parameters: six channels, 16-bit counters and a 3-bit divider select. Reload values near the top of the 16-bit range bring wraps within tens of clocks. Divider selects 0, 1, 3 and 7 cover the undivided rate, small division ratios and the largest ratio, 128. This makes first-wrap timing, repeat periods, the single-shot stop, a reload change mid-run and a clear landing on the wrap edge cheap to reach across several channels running at once.

// File: rtl/timer_pkg.sv
// Package: shared register offsets and control-field positions for the
// multi-channel auto-reload timer.
// Assumes: the register offset occupies the two low address bits.
package timer_pkg;

    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_RELOAD = 2'd1,
        REG_COUNT  = 2'd2,
        REG_STATUS = 2'd3
    } reg_sel_e;

    localparam int CTRL_EN_BIT      = 0;
    localparam int CTRL_ONESHOT_BIT = 1;
    localparam int CTRL_SEL_LSB     = 2;
    localparam int STAT_FLAG_BIT    = 0;

endpackage

// File: rtl/timer_prescaler.sv
// Module: per-channel clock divider producing a count-enable pulse.
// Behaviour: a free-running divider counter advances while run is high.
// tick fires when the low `sel` bits of the counter are all ones, which
// gives one pulse every 2^sel clocks. restart clears the counter.
// Assumes: sel is stable while running, or the resulting phase change is acceptable.
module timer_prescaler #(
    parameter int SEL_W = 3,
    localparam int DIV_W = (1 << SEL_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    // Mask of the low bits that must be all ones for a tick.
    always_comb begin
        mask = ~({DIV_W{1'b1}} << sel);
        tick = run && ((div_q & mask) == mask);
    end

    // Divider counter: cleared on reset or restart, advances while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (restart) begin
            div_q <= '0;
        end else if (run) begin
            div_q <= div_q + DIV_W'(1);
        end
    end

endmodule

// File: rtl/timer_addr_decode.sv
// Module: splits the register address into a one-hot channel select and
// per-channel write strobes for the control, reload and status registers.
// Assumes: addresses whose channel field is not below NUM_CH select nothing.
module timer_addr_decode #(
    parameter int NUM_CH = 6,
    parameter int CH_W   = 3,
    localparam int ADDR_W = CH_W + 2
) (
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    output logic [NUM_CH-1:0]     ch_hit,
    output timer_pkg::reg_sel_e   reg_sel,
    output logic [NUM_CH-1:0]     ctrl_we,
    output logic [NUM_CH-1:0]     reload_we,
    output logic [NUM_CH-1:0]     status_we
);
    import timer_pkg::*;

    logic [CH_W-1:0] ch_field;

    // Field split of the incoming address.
    always_comb begin
        ch_field = bus_addr[ADDR_W-1:2];
        reg_sel  = reg_sel_e'(bus_addr[1:0]);
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
        // Per-channel select and write strobes.
        always_comb begin
            ch_hit[i]    = (ch_field == CH_W'(i));
            ctrl_we[i]   = bus_wr && ch_hit[i] && (reg_sel == REG_CTRL);
            reload_we[i] = bus_wr && ch_hit[i] && (reg_sel == REG_RELOAD);
            status_we[i] = bus_wr && ch_hit[i] && (reg_sel == REG_STATUS);
        end
    end

endmodule

// File: rtl/timer_channel.sv
// Module: one auto-reload timer channel with its own prescaler, counter,
// reload register, control bits and sticky overflow flag.
// Assumes: at most one write strobe is active per cycle. Count writes are
// filtered out upstream.
module timer_channel #(
    parameter int CNT_W = 16,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic             reload_we,
    input  logic             status_we,
    input  logic [CNT_W-1:0] wdata,
    output logic             en,
    output logic             oneshot,
    output logic [SEL_W-1:0] sel,
    output logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             flag
);
    import timer_pkg::*;

    logic start;
    logic tick;
    logic wrap;

    // Start on an enable write to a stopped channel; wrap on a step from all ones.
    always_comb begin
        start = ctrl_we && wdata[CTRL_EN_BIT] && !en;
        wrap  = tick && (count == {CNT_W{1'b1}});
    end

    timer_prescaler #(.SEL_W(SEL_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start),
        .run     (en),
        .sel     (sel),
        .tick    (tick)
    );

    // Control bits: software write, or self-stop at a single-shot wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en      <= 1'b0;
            oneshot <= 1'b0;
            sel     <= '0;
        end else if (ctrl_we) begin
            en      <= wdata[CTRL_EN_BIT];
            oneshot <= wdata[CTRL_ONESHOT_BIT];
            sel     <= wdata[CTRL_SEL_LSB +: SEL_W];
        end else if (wrap && oneshot) begin
            en      <= 1'b0;
        end
    end

    // Reload register: written by software only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload <= '0;
        end else if (reload_we) begin
            reload <= wdata;
        end
    end

    // Counter: load at start, step on each tick, reload on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (start) begin
            count <= reload;
        end else if (wrap) begin
            count <= reload;
        end else if (tick) begin
            count <= count + CNT_W'(1);
        end
    end

    // Sticky overflow flag: a wrap sets it and takes priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (wrap) begin
            flag <= 1'b1;
        end else if (status_we && wdata[STAT_FLAG_BIT]) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/multi_reload_timer.sv
// Module: top of the multi-channel auto-reload timer. It decodes the register
// window, instantiates one channel per NUM_CH and multiplexes read data.
// Assumes: CNT_W is at least SEL_W + 2 so the control fields fit one word.
module multi_reload_timer #(
    parameter int NUM_CH = 6,
    parameter int CNT_W  = 16,
    parameter int SEL_W  = 3,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W = CH_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [NUM_CH-1:0] irq
);
    import timer_pkg::*;

    logic [NUM_CH-1:0]            ch_hit;
    reg_sel_e                     reg_sel;
    logic [NUM_CH-1:0]            ctrl_we;
    logic [NUM_CH-1:0]            reload_we;
    logic [NUM_CH-1:0]            status_we;
    logic [NUM_CH-1:0]            en_vec;
    logic [NUM_CH-1:0]            oneshot_vec;
    logic [NUM_CH-1:0]            flag_vec;
    logic [NUM_CH-1:0][SEL_W-1:0] sel_vec;
    logic [NUM_CH-1:0][CNT_W-1:0] reload_vec;
    logic [NUM_CH-1:0][CNT_W-1:0] cnt_vec;

    timer_addr_decode #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_dec (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .ch_hit    (ch_hit),
        .reg_sel   (reg_sel),
        .ctrl_we   (ctrl_we),
        .reload_we (reload_we),
        .status_we (status_we)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        timer_channel #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctrl_we   (ctrl_we[i]),
            .reload_we (reload_we[i]),
            .status_we (status_we[i]),
            .wdata     (bus_wdata),
            .en        (en_vec[i]),
            .oneshot   (oneshot_vec[i]),
            .sel       (sel_vec[i]),
            .reload    (reload_vec[i]),
            .count     (cnt_vec[i]),
            .flag      (flag_vec[i])
        );
    end

    // Interrupt outputs mirror the sticky flags.
    always_comb begin
        irq = flag_vec;
    end

    // Read multiplexer: selected channel and register, zero elsewhere.
    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            if (ch_hit[k]) begin
                case (reg_sel)
                    REG_CTRL:   bus_rdata = CNT_W'({sel_vec[k], oneshot_vec[k], en_vec[k]});
                    REG_RELOAD: bus_rdata = reload_vec[k];
                    REG_COUNT:  bus_rdata = cnt_vec[k];
                    REG_STATUS: bus_rdata = CNT_W'(flag_vec[k]);
                    default:    bus_rdata = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/timer_checker.sv
// Module: property checker for the multi-channel timer, attached by bind.
// Assumes: it sees the top's ports plus its per-channel state vectors.
module timer_checker #(
    parameter int NUM_CH = 6,
    parameter int CNT_W  = 16,
    parameter int CH_W   = 3,
    localparam int ADDR_W = CH_W + 2
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            bus_wr,
    input logic [ADDR_W-1:0]               bus_addr,
    input logic                            clr_bit,
    input logic [NUM_CH-1:0]               irq,
    input logic [NUM_CH-1:0]               en_vec,
    input logic [NUM_CH-1:0]               oneshot_vec,
    input logic [NUM_CH-1:0][CNT_W-1:0]    cnt_vec,
    input logic [NUM_CH-1:0][CNT_W-1:0]    reload_vec
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        logic hit_ctrl;
        logic hit_stat;

        // Writes aimed at this channel's control or status register.
        always_comb begin
            hit_ctrl = bus_wr && (bus_addr[ADDR_W-1:2] == CH_W'(i)) && (bus_addr[1:0] == 2'd0);
            hit_stat = bus_wr && (bus_addr[ADDR_W-1:2] == CH_W'(i)) && (bus_addr[1:0] == 2'd3);
        end

        assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (en_vec[i] && cnt_vec[i] != {CNT_W{1'b1}} && !bus_wr) |=>
            (cnt_vec[i] == $past(cnt_vec[i]) || cnt_vec[i] == $past(cnt_vec[i]) + CNT_W'(1)));

        assert_irq_after_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[i]) |-> ($past(cnt_vec[i]) == {CNT_W{1'b1}}));

        assert_oneshot_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (en_vec[i] && oneshot_vec[i] && cnt_vec[i] == {CNT_W{1'b1}} && !bus_wr) |=>
            ((en_vec[i] && cnt_vec[i] == {CNT_W{1'b1}}) ||
             (!en_vec[i] && cnt_vec[i] == $past(reload_vec[i]))));

        assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (irq[i] && !(hit_stat && clr_bit)) |=> irq[i]);

        assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_vec[i] && !hit_ctrl) |=> $stable(cnt_vec[i]));
    end

endmodule

bind multi_reload_timer timer_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .CH_W(CH_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .clr_bit     (bus_wdata[0]),
    .irq         (irq),
    .en_vec      (en_vec),
    .oneshot_vec (oneshot_vec),
    .cnt_vec     (cnt_vec),
    .reload_vec  (reload_vec)
);

// File: tb/multi_reload_timer_bench.sv
// Bench: scoreboard of expected interrupt edges per channel plus direct
// register checks. The driver pushes expected wrap cycles; a monitor pops
// them as irq bits rise.
module multi_reload_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH = 6;
    localparam int CNT_W  = 16;
    localparam int ADDR_W = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [CNT_W-1:0]  bus_wdata = '0;
    logic [CNT_W-1:0]  bus_rdata;
    logic [NUM_CH-1:0] irq;

    multi_reload_timer u_multi_reload_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    ch;
        int    at;
        string tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Caller is just after a negedge; the write lands on the next posedge.
    task automatic wr(input int ch, input int ofs, input int data, output int e);
        bus_wr    = 1'b1;
        bus_addr  = ADDR_W'(ch * 4 + ofs);
        bus_wdata = CNT_W'(data);
        @(negedge clk);
        bus_wr = 1'b0;
        e = cyc;
    endtask

    task automatic chk_reg(input string tag, input int ch, input int ofs, input int exp);
        bus_addr = ADDR_W'(ch * 4 + ofs);
        #1;
        check(tag, int'(bus_rdata), exp);
    endtask

    task automatic wait_cyc(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic push(input int ch, input int at, input string tag);
        exp_t it;
        it.ch = ch; it.at = at; it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: each rising irq bit consumes the oldest expectation for its channel.
    logic [NUM_CH-1:0] irq_prev = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            for (int ch = 0; ch < NUM_CH; ch++) begin
                if (irq[ch] && !irq_prev[ch]) begin
                    int idx;
                    idx = -1;
                    for (int j = 0; j < sb_q.size(); j++)
                        if (idx < 0 && sb_q[j].ch == ch) idx = j;
                    if (idx < 0) begin
                        check($sformatf("R7 unexpected irq rise ch%0d", ch), 1, 0);
                    end else begin
                        check(sb_q[idx].tag, cyc, sb_q[idx].at);
                        sb_q.delete(idx);
                    end
                end
            end
        end
        irq_prev = irq;
    end

    initial begin
        int e0, e1, e2, e3, e4, e5, e6, e, v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk_reg("R1 ctrl ch0", 0, 0, 0);
        chk_reg("R1 reload ch0", 0, 1, 0);
        chk_reg("R1 count ch0", 0, 2, 0);
        chk_reg("R1 status ch5", 5, 3, 0);
        check("R1 irq", int'(irq), 0);

        // R2..R5, R7: ch0 periodic, divide by 1, reload 0xFFF0
        wr(0, 1, 16'hFFF0, e);
        wr(0, 0, 16'h0001, e0);
        push(0, e0 + 16, "R4 first wrap ch0");
        push(0, e0 + 32, "R5 second wrap ch0");
        wait_cyc(e0 + 3);
        chk_reg("R3 count after 3 steps", 0, 2, 16'hFFF3);
        chk_reg("R2 ctrl readback", 0, 0, 16'h0001);
        wait_cyc(e0 + 17);
        chk_reg("R4 flag set", 0, 3, 1);
        chk_reg("R4 count after wrap", 0, 2, 16'hFFF1);
        check("R7 irq high", int'(irq[0]), 1);
        wr(0, 3, 0, e);
        chk_reg("R7 write 0 ignored", 0, 3, 1);
        wr(0, 3, 1, e);
        check("R7 irq cleared", int'(irq[0]), 0);
        wait_cyc(e0 + 33);
        chk_reg("R5 still enabled", 0, 0, 16'h0001);
        chk_reg("R5 count after second wrap", 0, 2, 16'hFFF1);
        wr(0, 0, 0, e);
        wr(0, 3, 1, e);
        bus_addr = ADDR_W'(2);
        #1 v = int'(bus_rdata);
        wait_cyc(cyc + 6);
        chk_reg("R10 stopped count holds", 0, 2, v);

        // R3, R6: ch1 single-shot, divide by 8, reload 0xFFF8
        wr(1, 1, 16'hFFF8, e);
        wr(1, 0, 16'h000F, e1);
        push(1, e1 + 64, "R6 single-shot wrap ch1");
        wait_cyc(e1 + 7);
        chk_reg("R3 div8 no step yet", 1, 2, 16'hFFF8);
        wait_cyc(e1 + 8);
        chk_reg("R3 div8 first step", 1, 2, 16'hFFF9);
        wait_cyc(e1 + 65);
        chk_reg("R6 enable cleared", 1, 0, 16'h000E);
        chk_reg("R6 count at reload", 1, 2, 16'hFFF8);
        chk_reg("R6 flag set", 1, 3, 1);
        wait_cyc(e1 + 100);
        chk_reg("R6 count still held", 1, 2, 16'hFFF8);
        wr(1, 3, 1, e);

        // R8: ch2 reload change mid-run, divide by 2
        wr(2, 1, 16'hFFF0, e);
        wr(2, 0, 16'h0005, e2);
        push(2, e2 + 32, "R8 wrap with old reload ch2");
        push(2, e2 + 48, "R8 wrap with new reload ch2");
        wait_cyc(e2 + 4);
        wr(2, 1, 16'hFFF8, e);
        wait_cyc(e2 + 10);
        chk_reg("R8 count unchanged by reload write", 2, 2, 16'hFFF5);
        wait_cyc(e2 + 33);
        chk_reg("R8 new reload used", 2, 2, 16'hFFF8);
        wr(2, 3, 1, e);
        wait_cyc(e2 + 49);
        chk_reg("R8 flag after second wrap", 2, 3, 1);
        wr(2, 0, 0, e);
        wr(2, 3, 1, e);

        // R9, R3: ch3 and ch5 running, ch4 written
        wr(3, 1, 16'hFFE0, e);
        wr(3, 0, 16'h0001, e3);
        push(3, e3 + 32, "R9 wrap ch3");
        wr(5, 1, 16'hFFFF, e);
        wr(5, 0, 16'h001D, e5);
        push(5, e5 + 128, "R3 div128 wrap ch5");
        wr(4, 1, 16'h1234, e);
        chk_reg("R9 ch4 reload written", 4, 1, 16'h1234);
        chk_reg("R9 ch4 count untouched", 4, 2, 0);
        chk_reg("R9 ch4 ctrl untouched", 4, 0, 0);
        wait_cyc(e3 + 20);
        chk_reg("R9 ch3 count unaffected", 3, 2, 16'hFFF4);
        wait_cyc(e5 + 127);
        chk_reg("R3 div128 before step", 5, 2, 16'hFFFF);
        wait_cyc(e5 + 129);
        chk_reg("R3 div128 flag", 5, 3, 1);
        wr(3, 0, 0, e);
        wr(5, 0, 0, e);
        wr(3, 3, 1, e);
        wr(5, 3, 1, e);

        // R7: clear in the wrap cycle leaves the flag set
        wr(4, 1, 16'hFFF0, e);
        wr(4, 0, 16'h0001, e4);
        push(4, e4 + 16, "R7 wrap ch4");
        wait_cyc(e4 + 15);
        wr(4, 3, 1, e);
        chk_reg("R7 set wins over clear", 4, 3, 1);
        check("R7 irq kept", int'(irq[4]), 1);
        wr(4, 3, 1, e);
        wr(4, 0, 0, e);
        check("R7 irq ch4 after clear", int'(irq[4]), 0);

        // R10: re-enable while running does not reload; stop holds
        wr(0, 1, 16'hFF00, e);
        wr(0, 0, 16'h0001, e6);
        wait_cyc(e6 + 5);
        wr(0, 0, 16'h0001, e);
        wait_cyc(e6 + 12);
        chk_reg("R10 no reload on repeat enable", 0, 2, 16'hFF0C);
        wr(0, 0, 0, e);
        chk_reg("R10 last step at stop edge", 0, 2, 16'hFF0D);
        wait_cyc(cyc + 5);
        chk_reg("R10 count held after stop", 0, 2, 16'hFF0D);

        wait_cyc(cyc + 10);
        foreach (sb_q[j]) check({sb_q[j].tag, " never seen"}, 0, 1);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule